// File: doc/BRIEF.md
# Size-Aware Shift and Rotate Unit

This block is the shift and rotate stage of an integer datapath. Each operation takes a source operand, a shift count, the old value of the destination register, an operand size of 1, 2, 4 or 8 bytes, a 3-bit opcode and the incoming carry flag. It produces the new destination value and a carry-out bit.

Only the low bytes covered by the operand size are rewritten. The bytes above them keep the old destination contents. Seven operations are supported:

- logical shift left
- logical shift right
- arithmetic shift right
- rotate left and rotate right
- rotate left and rotate right through the carry flag

The caller presents one operation per cycle with a valid strobe. The registered result and carry-out appear one cycle later, together with an output valid. The carry-out is meant to feed the carry input of a later operation, which lets wide shifts and multi-step rotates be chained. The block computes no condition flags other than this carry.

Top module: `shift_rot_unit`

## Requirements
- R1: The effective count is `count[5:0]` when `size_sel` is 3 (8 bytes). For `size_sel` 0, 1 and 2 (1, 2 and 4 bytes) it is `count[4:0]`, so count bit 5 is ignored at those sizes.
- R2: Logical shift right (opcode 1) fills every vacated bit inside the operand field with zero. At counts at or above the field width the field becomes all zero.
- R3: Arithmetic shift right (opcode 2) fills every vacated bit inside the field with the field's top bit, bit size*8-1. At counts above the width the field becomes all copies of that bit.
- R4: For the four rotate opcodes (3, 4, 5, 6) with an effective count of zero, and for the unused opcode 7, the result equals the old destination and the carry-out equals the carry input.
- R5: Rotate left (opcode 3) and rotate right (opcode 4) circulate the field by the effective count modulo the field width. Rotate left moves the top bits to the bottom; rotate right moves the low bits to the top.
- R6: Rotate right through carry (opcode 6) treats {carry, field} as a ring of width size*8+1 and rotates it right by the effective count. The carry lands at bit size*8-count, with the field's low bits directly above it.
- R7: Rotate left through carry (opcode 5) rotates the same ring left. The carry lands at bit count-1, with the field's top count-1 bits below it.
- R8: Only the low size*8 bits of the result come from the operation. All higher bits equal the old destination value.
- R9: An operation presented with `in_valid` high produces `out_valid` high and the new result and carry-out exactly one cycle later. While `in_valid` is low, `out_valid` is low the next cycle and the result holds.
- R10: The carry-out is the last bit moved out of the field. For the through-carry rotates it is the bit left in the carry slot of the ring. For shifts with a zero effective count it equals the carry input.
- R11: Logical shift left (opcode 0) fills vacated low bits with zero. At counts at or above the field width the field is zero; the carry is the field bit at position width-count, or zero beyond the width.
- R12: After a synchronous active-low reset, `out_valid`, `result` and `carry_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 3 | 0 shl, 1 shr, 2 sar, 3 rotl, 4 rotr, 5 rotl-carry, 6 rotr-carry, 7 keep |
| size_sel | input | 2 | Operand size: 0=1, 1=2, 2=4, 3=8 bytes |
| src_val | input | 64 | Source operand (low bytes used) |
| count | input | 6 | Shift or rotate count before masking |
| dest_old | input | 64 | Old destination register value |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 64 | Merged destination value |
| carry_out | output | 1 | Last bit shifted or rotated out |

## Verification
The assertions assume that while `in_valid` is high, every data input carries a defined value and holds steady through the sampling edge. They also assume reset is asserted for at least one edge before the first operation. The bench changes inputs only on the falling clock edge and holds `in_valid` low throughout reset. It leaves idle gaps between bursts so the hold and idle properties are exercised. Random operands cover all opcodes and sizes, and masked counts include zero, the width, and values above the width.

// File: rtl/shrot_pkg.sv
// Package: shared opcode encoding for the shift and rotate unit.
// Assumes a 3-bit opcode field; code 7 is a no-operation that keeps the destination.
package shrot_pkg;
    typedef enum logic [2:0] {
        OP_SHL   = 3'd0,
        OP_SHR   = 3'd1,
        OP_SAR   = 3'd2,
        OP_ROTL  = 3'd3,
        OP_ROTR  = 3'd4,
        OP_RCYL  = 3'd5,
        OP_RCYR  = 3'd6,
        OP_KEEP  = 3'd7
    } op_e;
endpackage

// File: rtl/shrot_count_mask.sv
// Module: derives the effective count from the raw count and the operand size.
// Assumes the widest size code is NUM_SIZES-1 and that only it may use the top count bit.
module shrot_count_mask #(
    parameter int CNT_W     = 6,
    parameter int SIZE_W    = 2,
    parameter int NUM_SIZES = 4
) (
    input  logic [SIZE_W-1:0] size_sel,
    input  logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  eff_count
);
    localparam logic [SIZE_W-1:0] WIDEST = SIZE_W'(NUM_SIZES - 1);

    // Purpose: drop the count's top bit unless the widest size is selected.
    always_comb begin
        if (size_sel == WIDEST) eff_count = count;
        else                    eff_count = {1'b0, count[CNT_W-2:0]};
    end
endmodule

// File: rtl/shrot_lane.sv
// Module: computes one operation for a single fixed field width W.
// Assumes W is a power of two no wider than 2**CNT_W; "keep" requests the old destination.
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 6
) (
    input  op_e              op,
    input  logic [W-1:0]     src_f,
    input  logic [CNT_W-1:0] k,
    input  logic             cin,
    output logic [W-1:0]     res,
    output logic             cout,
    output logic             keep
);
    localparam int RW = $clog2(W);
    localparam logic [RW:0]    WL   = (RW+1)'(W);
    localparam logic [CNT_W:0] MODV = (CNT_W+1)'(W+1);

    logic [CNT_W:0] km;
    logic [RW-1:0]  kr;
    logic           k_zero;
    logic [W:0]     shl_x, shr_x, sar_x;
    logic [W-1:0]   rol_x, ror_x;
    logic [W:0]     ring, rcl_x, rcr_x;

    assign k_zero = (k == '0);
    assign kr     = k[RW-1:0];
    assign km     = {1'b0, k} % MODV;
    assign ring   = {cin, src_f};

    // Purpose: shifts with one spare bit that captures the last bit moved out.
    assign shl_x = {1'b0, src_f} << k;
    assign shr_x = {src_f, 1'b0} >> k;
    assign sar_x = $signed({src_f, 1'b0}) >>> k;

    // Purpose: plain rotates modulo W and through-carry rotates modulo W+1.
    assign rol_x = (src_f << kr) | (src_f >> (WL - {1'b0, kr}));
    assign ror_x = (src_f >> kr) | (src_f << (WL - {1'b0, kr}));
    assign rcl_x = (ring << km) | (ring >> (MODV - km));
    assign rcr_x = (ring >> km) | (ring << (MODV - km));

    // Purpose: select the field result, carry-out and keep request by opcode.
    always_comb begin
        res  = src_f;
        cout = cin;
        keep = 1'b0;
        case (op)
            OP_SHL:  if (!k_zero) begin res = shl_x[W-1:0]; cout = shl_x[W]; end
            OP_SHR:  if (!k_zero) begin res = shr_x[W:1];   cout = shr_x[0]; end
            OP_SAR:  if (!k_zero) begin res = sar_x[W:1];   cout = sar_x[0]; end
            OP_ROTL: if (k_zero) keep = 1'b1;
                     else begin res = rol_x; cout = rol_x[0]; end
            OP_ROTR: if (k_zero) keep = 1'b1;
                     else begin res = ror_x; cout = ror_x[W-1]; end
            OP_RCYL: if (k_zero) keep = 1'b1;
                     else begin res = rcl_x[W-1:0]; cout = rcl_x[W]; end
            OP_RCYR: if (k_zero) keep = 1'b1;
                     else begin res = rcr_x[W-1:0]; cout = rcr_x[W]; end
            default: keep = 1'b1;
        endcase
    end
endmodule

// File: rtl/shrot_merge.sv
// Module: writes the operation field into the low bytes of the old destination.
// Assumes size code s selects 2**s bytes; keep returns the destination unchanged.
module shrot_merge #(
    parameter int DATA_W = 64,
    parameter int SIZE_W = 2
) (
    input  logic [SIZE_W-1:0] size_sel,
    input  logic              keep,
    input  logic [DATA_W-1:0] field,
    input  logic [DATA_W-1:0] dest_old,
    output logic [DATA_W-1:0] merged
);
    localparam int NBYTES = DATA_W / 8;
    localparam int NB_W   = $clog2(NBYTES) + 1;

    logic [NB_W-1:0] live_bytes;
    assign live_bytes = NB_W'(1) << size_sel;

    // Purpose: per byte, take the field when it lies inside the operand size.
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign merged[8*b +: 8] = (!keep && (NB_W'(b) < live_bytes))
                                  ? field[8*b +: 8] : dest_old[8*b +: 8];
    end
endmodule

// File: rtl/shift_rot_unit.sv
// Module: size-aware shift and rotate unit with a one-cycle registered result.
// Assumes inputs are stable around the clock edge when in_valid is high;
// one lane per operand size is built and the size code picks the lane.
module shift_rot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [2:0]                   op_sel,
    input  logic [$clog2($clog2(DATA_W/8)+1)-1:0] size_sel,
    input  logic [DATA_W-1:0]            src_val,
    input  logic [$clog2(DATA_W)-1:0]    count,
    input  logic [DATA_W-1:0]            dest_old,
    input  logic                         carry_in,
    output logic                         out_valid,
    output logic [DATA_W-1:0]            result,
    output logic                         carry_out
);
    localparam int NUM_SIZES = $clog2(DATA_W/8) + 1;
    localparam int SIZE_W    = $clog2(NUM_SIZES);
    localparam int CNT_W     = $clog2(DATA_W);
    localparam logic [SIZE_W-1:0] WIDEST = SIZE_W'(NUM_SIZES - 1);

    logic [CNT_W-1:0]  eff_count;
    logic [DATA_W-1:0] lane_res  [NUM_SIZES];
    logic              lane_cout [NUM_SIZES];
    logic              lane_keep [NUM_SIZES];
    logic [DATA_W-1:0] merged;
    op_e               op;

    assign op = op_e'(op_sel);

    shrot_count_mask #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .NUM_SIZES(NUM_SIZES)) u_cnt (
        .size_sel (size_sel),
        .count    (count),
        .eff_count(eff_count)
    );

    // Purpose: one operation lane per supported operand width.
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
        localparam int LW = 8 << g;
        logic [LW-1:0] res_g;
        shrot_lane #(.W(LW), .CNT_W(CNT_W)) u_lane (
            .op   (op),
            .src_f(src_val[LW-1:0]),
            .k    (eff_count),
            .cin  (carry_in),
            .res  (res_g),
            .cout (lane_cout[g]),
            .keep (lane_keep[g])
        );
        assign lane_res[g] = DATA_W'(res_g);
    end

    shrot_merge #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_merge (
        .size_sel(size_sel),
        .keep    (lane_keep[size_sel]),
        .field   (lane_res[size_sel]),
        .dest_old(dest_old),
        .merged  (merged)
    );

    // Purpose: capture the merged result and carry on each valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            carry_out <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= merged;
                carry_out <= lane_cout[size_sel];
            end
        end
    end

    logic rot_op, zero_cnt;
    assign rot_op   = (op_sel == 3'd3) || (op_sel == 3'd4) || (op_sel == 3'd5) || (op_sel == 3'd6);
    assign zero_cnt = ((size_sel == WIDEST) ? count
                       : (count & ~(CNT_W'(1) << (CNT_W-1)))) == '0;

    // R9: output valid follows the strobe by one cycle; idle cycles hold the result.
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    // R8: bytes above the operand size carry the old destination.
    p_upper_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((result >> (8 << $past(size_sel))) ==
                      ($past(dest_old) >> (8 << $past(size_sel)))));

    // R4: a rotate with zero effective count changes neither destination nor carry.
    p_rot_zero_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rot_op && zero_cnt) |=>
        (result == $past(dest_old) && carry_out == $past(carry_in)));

    // R2: a full-width logical right shift clears the top bit.
    p_shr_zero_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd1 && size_sel == WIDEST && count != '0) |=>
        (result[DATA_W-1] == 1'b0));

    // R3: a full-width arithmetic right shift keeps the sign bit.
    p_sar_sign_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd2 && size_sel == WIDEST && count != '0) |=>
        (result[DATA_W-1] == $past(src_val[DATA_W-1])));
endmodule

// File: tb/shift_rot_unit_tb_top.sv
module shift_rot_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [1:0]  size_sel = '0;
    logic [63:0] src_val = '0;
    logic [5:0]  count = '0;
    logic [63:0] dest_old = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        carry_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] r;
        logic        c;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    shift_rot_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .size_sel(size_sel), .src_val(src_val), .count(count),
        .dest_old(dest_old), .carry_in(carry_in), .out_valid(out_valid),
        .result(result), .carry_out(carry_out)
    );

    // Reference model built bit by bit from the requirements.
    function automatic void ref_op(input int op, input int sz, input logic [63:0] s,
                                   input logic [5:0] cnt, input logic [63:0] d,
                                   input logic cin, output logic [63:0] r, output logic co);
        int w;
        int k;
        logic [63:0] f;
        logic [63:0] o;
        logic cf;
        logic t;
        w = 8 << sz;
        k = (sz == 3) ? int'(cnt) : int'(cnt[4:0]);
        f = '0;
        for (int i = 0; i < w; i++) f[i] = s[i];
        o = '0;
        co = cin;
        if (op == 7 || (op >= 3 && k == 0)) begin
            r = d;
            return;
        end
        case (op)
            0: begin
                for (int i = 0; i < w; i++) o[i] = (i >= k) ? f[i-k] : 1'b0;
                if (k > 0) co = (k <= w) ? f[w-k] : 1'b0;
            end
            1: begin
                for (int i = 0; i < w; i++) o[i] = (i + k < w) ? f[i+k] : 1'b0;
                if (k > 0) co = (k <= w) ? f[k-1] : 1'b0;
            end
            2: begin
                for (int i = 0; i < w; i++) o[i] = (i + k < w) ? f[i+k] : f[w-1];
                if (k > 0) co = (k <= w) ? f[k-1] : f[w-1];
            end
            3: begin
                for (int j = 0; j < k; j++) begin t = f[w-1]; f = f << 1; f[0] = t; co = t; end
                o = f;
            end
            4: begin
                for (int j = 0; j < k; j++) begin t = f[0]; f = f >> 1; f[w-1] = t; co = t; end
                o = f;
            end
            5: begin
                cf = cin;
                for (int j = 0; j < k; j++) begin t = f[w-1]; f = f << 1; f[0] = cf; cf = t; end
                o = f; co = cf;
            end
            default: begin
                cf = cin;
                for (int j = 0; j < k; j++) begin t = f[0]; f = f >> 1; f[w-1] = cf; cf = t; end
                o = f; co = cf;
            end
        endcase
        r = d;
        for (int i = 0; i < w; i++) r[i] = o[i];
    endfunction

    // Driver: present one operation and queue its expected outcome.
    task automatic drive(input int op, input int sz, input logic [63:0] s, input logic [5:0] cnt,
                         input logic [63:0] d, input logic cin, input string tag);
        exp_t e;
        @(negedge clk);
        op_sel = 3'(op); size_sel = 2'(sz); src_val = s; count = cnt;
        dest_old = d; carry_in = cin; in_valid = 1'b1;
        ref_op(op, sz, s, cnt, d, cin, e.r, e.c);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare each produced result against the queue; check idle hold (R9).
    logic [63:0] last_res = '0;
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (rst_n) begin
            if (out_valid) begin
                checks++;
                if (sb_q.size() == 0) begin
                    failures++;
                    $display("FAIL R9 unexpected out_valid actual=1 expected=0");
                end else begin
                    e = sb_q.pop_front();
                    if (result !== e.r || carry_out !== e.c) begin
                        failures++;
                        $display("FAIL %s actual=%h/%b expected=%h/%b", e.tag, result, carry_out, e.r, e.c);
                    end
                end
            end else begin
                checks++;
                if (result !== last_res) begin
                    failures++;
                    $display("FAIL R9 idle hold actual=%h expected=%h", result, last_res);
                end
            end
            last_res = result;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (out_valid !== 1'b0 || result !== 64'h0 || carry_out !== 1'b0) begin
            failures++;
            $display("FAIL R12 reset actual=%b/%h/%b expected=0/0/0", out_valid, result, carry_out);
        end
        @(negedge clk);
        rst_n = 1'b1;

        drive(0, 0, 64'h81, 6'h21, 64'hFFFF_FFFF_FFFF_FF00, 1'b0, "R1 count bit5 dropped at 1B");
        drive(0, 3, 64'h1, 6'h21, 64'h0, 1'b0, "R1 count bit5 kept at 8B");
        drive(1, 2, 64'hFFFF_FFFF, 6'h20, 64'h0, 1'b1, "R1 shr count masked to 0 at 4B");
        drive(0, 0, 64'hA5, 6'd8, 64'h1234, 1'b0, "R11 shl by width");
        drive(0, 1, 64'h8001, 6'd3, 64'h0, 1'b1, "R11 shl 2B");
        drive(0, 0, 64'hFF, 6'd20, 64'h0, 1'b1, "R11 shl past width");
        drive(1, 1, 64'h8000, 6'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R2 shr zero fill 2B");
        drive(1, 3, 64'hF000_0000_0000_0001, 6'd63, 64'h0, 1'b0, "R2 shr 8B by 63");
        drive(2, 2, 64'h8000_0000, 6'd4, 64'h0, 1'b0, "R3 sar sign 4B");
        drive(2, 0, 64'h80, 6'd20, 64'h0, 1'b0, "R3 sar past width");
        drive(3, 0, 64'h12, 6'h20, 64'hDEAD, 1'b1, "R4 rotl masked zero");
        drive(6, 1, 64'h1234, 6'd0, 64'hBEEF, 1'b0, "R4 rotr-carry zero count");
        drive(7, 3, 64'h1234, 6'd5, 64'hCAFE, 1'b1, "R4 opcode 7 keeps dest");
        idle(3);
        drive(4, 0, 64'h01, 6'd1, 64'h0, 1'b0, "R5 rotr 1B");
        drive(3, 3, 64'h8000_0000_0000_0001, 6'd63, 64'h0, 1'b0, "R5 rotl 8B by 63");
        drive(3, 0, 64'h81, 6'd9, 64'h0, 1'b0, "R5 rotl mod width");
        drive(6, 0, 64'h01, 6'd1, 64'h0, 1'b1, "R6 rotr-carry by 1");
        drive(6, 0, 64'h5A, 6'd9, 64'h0, 1'b1, "R6 rotr-carry full ring");
        drive(6, 2, 64'h1234_5678, 6'd31, 64'h0, 1'b0, "R6 rotr-carry 4B");
        drive(5, 1, 64'hC001, 6'd3, 64'h0, 1'b1, "R7 rotl-carry 2B");
        drive(5, 3, 64'h8000_0000_0000_0000, 6'd1, 64'h0, 1'b0, "R7 rotl-carry 8B");
        drive(5, 0, 64'h80, 6'd17, 64'h0, 1'b1, "R7 rotl-carry wraps");
        drive(0, 1, 64'hFFFF_FFFF_FFFF_0001, 6'd1, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, "R8 merge 2B");
        drive(4, 2, 64'h1111_1111_0000_0001, 6'd4, 64'h5555_5555_5555_5555, 1'b0, "R8 merge 4B");
        idle(2);
        for (int n = 0; n < 600; n++) begin
            drive($urandom_range(0, 7), $urandom_range(0, 3), {$urandom, $urandom},
                  6'($urandom), {$urandom, $urandom}, 1'($urandom), "R10 random carry/result");
            if ((n % 37) == 0) idle(2);
        end
        idle(4);
        done = 1'b1;
        checks++;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL R9 pending actual=%0d expected=0", sb_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule